// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block decides, once per machine cycle, whether a small 8-bit CPU should be diverted into an interrupt service routine and, if so, which one. Six sources present already-latched pending flags. Each source has its own enable bit and two priority bits, and one global enable gates all six. Each source's two bits form one of four priority levels. The block keeps a per-level record of routines that have been entered and not yet closed, so a running routine can only be pre-empted by a strictly higher level.

When a winner exists, the CPU is at the last cycle of an instruction that does not block interrupts, and no earlier acknowledge call is still in flight, the block issues a one-clock vector request. The request carries the winner's fixed vector address and level. A matching acknowledge pulse goes back to the winning source. The CPU signals a dedicated return-from-interrupt, and this closes the most recently opened level. An ordinary subroutine return is not seen here, so it leaves that level blocked.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, vec_req is 0, src_ack is 0, vec_addr is 0 and no priority level is marked in progress.
- R2: A source's level is {prio_hi[i], prio_lo[i]}, where 3 is highest and 0 is lowest. Among eligible pending sources, the highest level wins.
- R3: Among eligible pending sources at the same level, the lowest index wins. The index order is 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R4: A pending source is eligible only when both its en_mask bit and glob_en are 1.
- R5: An accept happens at a rising clock edge. In the clock after that edge, vec_req is 1 for exactly that one clock. During that clock, vec_addr is 8*index+3 (for example 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B) and vec_level is the winner's level.
- R6: An accept needs cycle_en=1, last_cycle=1, blk_instr=0 and reti=0 at that edge.
- R7: While any level is in progress, a winner is accepted only if its level is strictly above the highest level in progress. A winner at an equal or lower level waits.
- R8: An accept marks the winner's level as in progress. A reti strobe (reti=1 with cycle_en=1) clears only the highest level in progress. Nothing else clears a level.
- R9: src_ack is a one-hot pulse on the winner's bit, in the same clock as vec_req. The serial source (bit 4) never receives an acknowledge.
- R10: After an accept, the next CALL_CYCLES machine-cycle strobes (default 2) cannot accept. The strobe after those can accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_en | input | 1 | Machine-cycle strobe |
| pend | input | 6 | Latched pending flags from the sources |
| en_mask | input | 6 | Per-source enable bits |
| glob_en | input | 1 | Global interrupt enable |
| prio_hi | input | 6 | High priority bit per source |
| prio_lo | input | 6 | Low priority bit per source |
| last_cycle | input | 1 | Current instruction is in its final cycle |
| blk_instr | input | 1 | Current instruction writes enable or priority settings |
| reti | input | 1 | Current instruction is a return from interrupt |
| vec_req | output | 1 | One-clock vector call request |
| vec_addr | output | 16 | Vector address of the accepted source |
| vec_level | output | 2 | Level of the accepted source |
| src_ack | output | 6 | One-hot acknowledge to the accepted source |

## Verification
A table of single-cycle patterns isolates the winner selection. It covers a lone source at each end of the index order, level beating index, equal levels resolved by index, a global disable, a per-source disable, and a serial winner that must carry no acknowledge. Directed sequences then nest routines by level. These show that an equal level waits and a higher one pre-empts. They also show that each return strobe unblocks exactly one level, while idle cycles without a return unblock nothing. Separate patterns hold a request pending while a blocking condition or the call-hold window is active, to show the accept is deferred rather than lost.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_mask_t;

  // highest set bit of an in-progress mask
  function automatic lvl_t top_level(input lvl_mask_t m);
    lvl_t t;
    t = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (m[i]) t = lvl_t'(i);
    end
    return t;
  endfunction
endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       en_mask,
  input  logic                     glob_en,
  input  logic [NUM_SRC-1:0]       prio_hi,
  input  logic [NUM_SRC-1:0]       prio_lo,
  output logic [NUM_SRC-1:0]       elig,
  output logic [NUM_SRC-1:0][LVL_W-1:0] lvl
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign elig[g] = pend[g] & en_mask[g] & glob_en;
    assign lvl[g]  = {prio_hi[g], prio_lo[g]};
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 6,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            elig,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          found,
  output logic [IDX_W-1:0]              win_idx,
  output lvl_t                          win_lvl
);
  // strict compare keeps the lower index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!found || (lvl[i] > win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  lvl_t      push_lvl,
  input  logic      pop,
  output lvl_mask_t mask,
  output logic      busy,
  output lvl_t      top_lvl
);
  lvl_mask_t mask_q, mask_d;

  always_comb begin
    logic cleared;
    mask_d  = mask_q;
    cleared = 1'b0;
    if (pop) begin
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
        if (!cleared && mask_q[i]) begin
          mask_d[i] = 1'b0;
          cleared   = 1'b1;
        end
      end
    end
    if (push) mask_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mask_q <= '0;
    else if (push || pop)   mask_q <= mask_d;
  end

  assign mask    = mask_q;
  assign busy    = |mask_q;
  assign top_lvl = top_level(mask_q);

  AST_PUSH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> mask_q[$past(push_lvl)]); // R8
  AST_POP_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (mask_q != '0)) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(mask_q)); // R8
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  parameter int CALL_CYCLES = 2,
  parameter logic [NUM_SRC-1:0] NO_ACK_MASK = 6'b010000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_en,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic               glob_en,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic               last_cycle,
  input  logic               blk_instr,
  input  logic               reti,
  output logic               vec_req,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [LVL_W-1:0]   vec_level,
  output logic [NUM_SRC-1:0] src_ack
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int HOLD_W = $clog2(CALL_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SRC-1:0]            elig;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic                          win_found;
  logic [IDX_W-1:0]              win_idx;
  lvl_t                          win_lvl;
  lvl_mask_t                     stk_mask;
  logic                          stk_busy;
  lvl_t                          stk_top;

  irq_src_qual #(.NUM_SRC(NUM_SRC)) u_qual (
    .pend(pend), .en_mask(en_mask), .glob_en(glob_en),
    .prio_hi(prio_hi), .prio_lo(prio_lo), .elig(elig), .lvl(lvl)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .elig(elig), .lvl(lvl), .found(win_found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  logic hold_free, may_preempt, slot_ok, accept, pop;
  logic [HOLD_W-1:0] hold_q, hold_d;

  assign hold_free   = (hold_q == '0);
  assign may_preempt = !stk_busy || (win_lvl > stk_top);
  assign slot_ok     = cycle_en && last_cycle && !blk_instr && !reti;
  assign accept      = slot_ok && hold_free && win_found && may_preempt;
  assign pop         = cycle_en && reti;

  irq_level_stack u_stack (
    .clk(clk), .rst_n(rst_int_n), .push(accept), .push_lvl(win_lvl), .pop(pop),
    .mask(stk_mask), .busy(stk_busy), .top_lvl(stk_top)
  );

  // call-hold counter
  always_comb begin
    hold_d = hold_q;
    if (accept)                    hold_d = HOLD_W'(CALL_CYCLES);
    else if (cycle_en && !hold_free) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hold_q <= '0;
    else            hold_q <= hold_d;
  end

  // output stage
  logic               req_d;
  logic [ADDR_W-1:0]  addr_d;
  lvl_t               lvl_d;
  logic [NUM_SRC-1:0] ack_d;

  always_comb begin
    req_d  = accept;
    addr_d = vec_addr;
    lvl_d  = vec_level;
    ack_d  = '0;
    if (accept) begin
      addr_d         = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP);
      lvl_d          = win_lvl;
      ack_d[win_idx] = 1'b1;
      ack_d          = ack_d & ~NO_ACK_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_req   <= 1'b0;
      vec_addr  <= '0;
      vec_level <= '0;
      src_ack   <= '0;
    end else begin
      vec_req   <= req_d;
      src_ack   <= ack_d;
      if (accept) begin
        vec_addr  <= addr_d;
        vec_level <= lvl_d;
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(src_ack)); // R9
  AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_ack != '0) |-> vec_req); // R9
  AST_REQ_SLOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_req |-> $past(cycle_en && last_cycle && !blk_instr && !reti)); // R6
  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_req |-> (($past(stk_mask) == '0) || (vec_level > top_level($past(stk_mask))))); // R7
  AST_LEVEL_MARKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_req |-> stk_mask[vec_level]); // R8
  AST_CALL_GAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_req |=> !vec_req); // R10
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cycle_en = 1'b1, glob_en = 1'b0;
  logic [5:0] pend = '0, en_mask = '0, prio_hi = '0, prio_lo = '0;
  logic last_cycle = 1'b0, blk_instr = 1'b0, reti = 1'b0;
  logic vec_req;
  logic [15:0] vec_addr;
  logic [1:0] vec_level;
  logic [5:0] src_ack;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cycle_en(cycle_en), .pend(pend), .en_mask(en_mask),
    .glob_en(glob_en), .prio_hi(prio_hi), .prio_lo(prio_lo), .last_cycle(last_cycle),
    .blk_instr(blk_instr), .reti(reti), .vec_req(vec_req), .vec_addr(vec_addr),
    .vec_level(vec_level), .src_ack(src_ack)
  );

  // pend, en, glob, hi, lo, expect request, expected source index
  localparam logic [28:0] VEC_TBL [0:7] = '{
    {6'b000001, 6'b111111, 1'b1, 6'b000000, 6'b000000, 1'b1, 3'd0},
    {6'b100000, 6'b111111, 1'b1, 6'b000000, 6'b000000, 1'b1, 3'd5},
    {6'b111111, 6'b111111, 1'b0, 6'b000000, 6'b000000, 1'b0, 3'd0},
    {6'b000110, 6'b000100, 1'b1, 6'b000000, 6'b000000, 1'b1, 3'd2},
    {6'b100001, 6'b111111, 1'b1, 6'b100000, 6'b000000, 1'b1, 3'd5},
    {6'b010010, 6'b111111, 1'b1, 6'b000000, 6'b010010, 1'b1, 3'd1},
    {6'b011000, 6'b111111, 1'b1, 6'b000000, 6'b010000, 1'b1, 3'd4},
    {6'b001100, 6'b111111, 1'b1, 6'b001000, 6'b000100, 1'b1, 3'd3}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; last_cycle = 1'b0; pend = '0; reti = 1'b0; blk_instr = 1'b0; cycle_en = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic offer(input logic [5:0] p, input logic [5:0] e, input logic g,
                       input logic [5:0] h, input logic [5:0] l);
    pend = p; en_mask = e; glob_en = g; prio_hi = h; prio_lo = l; last_cycle = 1'b1;
  endtask

  task automatic settle();
    last_cycle = 1'b0; pend = '0; reti = 1'b0; blk_instr = 1'b0; cycle_en = 1'b1;
    repeat (4) tick();
  endtask

  task automatic ret_strobe();
    reti = 1'b1; tick(); reti = 1'b0; tick();
  endtask

  task automatic expect_out(input string req, input logic er, input int src, input logic [1:0] elv);
    logic [15:0] ea;
    logic [5:0] ek;
    ea = 16'(8 * src + 3);
    ek = (src == 4) ? 6'b0 : 6'(1 << src);
    if (!er) ek = '0;
    total++;
    if (vec_req !== er || (er && (vec_addr !== ea || vec_level !== elv)) || src_ack !== ek) begin
      bad++;
      $display("FAIL %s: req=%b addr=%h lvl=%0d ack=%b expected req=%b addr=%h lvl=%0d ack=%b",
               req, vec_req, vec_addr, vec_level, src_ack, er, ea, elv, ek);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    total++;
    if (vec_req !== 1'b0 || src_ack !== '0 || vec_addr !== '0) begin
      bad++;
      $display("FAIL R1: req=%b ack=%b addr=%h expected 0 0 0000", vec_req, src_ack, vec_addr);
    end

    // table: R2 R3 R4 R5 R9
    for (int k = 0; k < 8; k++) begin
      logic [28:0] v;
      int s;
      v = VEC_TBL[k];
      s = int'(v[2:0]);
      do_reset();
      offer(v[28:23], v[22:17], v[16], v[15:10], v[9:4]);
      tick();
      expect_out($sformatf("R2/R3/R4/R5/R9 row %0d", k), v[3], s, {v[15 - 5 + s], v[9 - 5 + s]});
      settle();
    end

    // R6 blocking conditions, request kept pending
    do_reset();
    offer(6'b000001, 6'b111111, 1'b1, 6'b0, 6'b0);
    last_cycle = 1'b0; tick(); expect_out("R6 not final cycle", 1'b0, 0, 2'd0);
    last_cycle = 1'b1; blk_instr = 1'b1; tick(); expect_out("R6 blocking instr", 1'b0, 0, 2'd0);
    blk_instr = 1'b0; reti = 1'b1; tick(); expect_out("R6 reti instr", 1'b0, 0, 2'd0);
    reti = 1'b0; cycle_en = 1'b0; tick(); expect_out("R6 no strobe", 1'b0, 0, 2'd0);
    cycle_en = 1'b1; tick(); expect_out("R6 deferred accept", 1'b1, 0, 2'd0);
    settle();

    // R7 R8 nesting
    do_reset();
    offer(6'b000001, 6'b111111, 1'b1, 6'b0, 6'b000001); tick();
    expect_out("R7 first at level 1", 1'b1, 0, 2'd1); settle();
    offer(6'b000010, 6'b111111, 1'b1, 6'b0, 6'b000010); tick();
    expect_out("R7 equal level waits", 1'b0, 1, 2'd1); settle();
    offer(6'b000010, 6'b111111, 1'b1, 6'b0, 6'b0); tick();
    expect_out("R7 lower level waits", 1'b0, 1, 2'd0); settle();
    offer(6'b000100, 6'b111111, 1'b1, 6'b000100, 6'b0); tick();
    expect_out("R7 higher pre-empts", 1'b1, 2, 2'd2); settle();
    ret_strobe();
    offer(6'b000100, 6'b111111, 1'b1, 6'b000100, 6'b0); tick();
    expect_out("R8 reti reopens level 2", 1'b1, 2, 2'd2); settle();
    repeat (10) tick();
    offer(6'b000010, 6'b111111, 1'b1, 6'b0, 6'b000010); tick();
    expect_out("R8 no reti keeps block", 1'b0, 1, 2'd1); settle();
    ret_strobe();
    offer(6'b000010, 6'b111111, 1'b1, 6'b0, 6'b000010); tick();
    expect_out("R8 one reti clears top only", 1'b0, 1, 2'd1); settle();
    ret_strobe();
    offer(6'b000010, 6'b111111, 1'b1, 6'b0, 6'b000010); tick();
    expect_out("R8 second reti frees level 1", 1'b1, 1, 2'd1); settle();

    // R10 call hold window
    do_reset();
    offer(6'b000001, 6'b111111, 1'b1, 6'b0, 6'b0); tick();
    expect_out("R10 initial accept", 1'b1, 0, 2'd0);
    offer(6'b001000, 6'b111111, 1'b1, 6'b001000, 6'b001000);
    tick(); expect_out("R10 hold strobe 1", 1'b0, 3, 2'd3);
    tick(); expect_out("R10 hold strobe 2", 1'b0, 3, 2'd3);
    tick(); expect_out("R10 accept after hold", 1'b1, 3, 2'd3);
    settle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule